// File: doc/BRIEF.md
# Store-Path Rounding and Saturation Unit

This block conditions lane values on their way to memory. Each of eight lanes carries a signed 40-bit value. One 16-bit control word is shared by all lanes. It selects an optional right shift, either rounded to nearest or truncated, and then a clamp. The clamp can be symmetric, asymmetric, four-value replacement, or one of two variants that use 32-bit bounds. The bound values arrive as four 16-bit words. The surrounding pipeline has already fetched these words, along with the control word. A flag taken from the store type says whether the bound words are read as signed or unsigned numbers. Every comparison is made against the signed lane value.

The unit sits in the store stage and has a fixed latency of one clock whatever mode is selected, so it adds no cycles to a store. An all-zero control word passes every lane through unchanged. This makes it the natural setting when no conditioning is wanted.

Top module: `rsat_store_cond`

## Requirements
- R1: While `rst_n` is low, `lane_out` is all zero. Reset is asynchronous.
- R2: Every lane result appears on `lane_out` at the first rising clock edge after the inputs are applied, for every mode. Between edges the output keeps its previous value.
- R3: Control word layout: bits [15:13] select the clamp mode, bits [12:8] hold a bound index, bits [7:6] select the shift mode and bits [5:0] hold the shift count. The bound index has no effect on the result.
- R4: An all-zero control word passes each lane unchanged. Shift mode 0 (off) and shift mode 3 perform no shift, whatever the shift count.
- R5: Shift mode 1 (round) gives (x + 2^(s-1)) >>> s for a shift count s of 1 or more, using an arithmetic shift. A count of 0 leaves x unchanged.
- R6: Shift mode 2 (truncate) gives x >>> s, which rounds toward minus infinity.
- R7: The clamp acts on the shifted value. Clamp modes 0, 6 and 7 apply no clamp. A value already inside the window is left unchanged.
- R8: Clamp mode 1 (symmetric) takes B from word 0 (`bound_words[15:0]`) and limits the value to [-B, B].
- R9: Clamp mode 2 (asymmetric) takes the lower bound from word 0 and the upper bound from word 1 (`bound_words[31:16]`). The upper test is made first: a value above the upper bound becomes the upper bound, otherwise a value below the lower bound becomes the lower bound.
- R10: Clamp mode 3 (replace) uses the same bounds as mode 2. A value above the upper bound becomes word 3 (`bound_words[63:48]`), and a value below the lower bound becomes word 2 (`bound_words[47:32]`).
- R11: Clamp mode 4 is symmetric with B = {word 1, word 0}. Clamp mode 5 is asymmetric with lower bound {word 1, word 0} and upper bound {word 3, word 2}.
- R12: When `bound_signed` is 1, bound words are sign-extended; when it is 0 they are zero-extended. The comparison is signed against the lane value.
- R13: Lanes are processed independently. Lane k occupies bits [40k+39:40k] of `lane_in` and `lane_out`, and all lanes share one control word and one set of bound words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lane_in | input | 320 | Eight signed 40-bit lane values |
| ctrl_word | input | 16 | Shift and clamp control word |
| bound_words | input | 64 | Four 16-bit bound words, word 0 in the low bits |
| bound_signed | input | 1 | 1: bounds are signed, 0: bounds are unsigned |
| lane_out | output | 320 | Eight conditioned 40-bit lane values |

## Verification
Rounding and clamping can act on the same lane in the same cycle. Their order decides the result. The bench provokes this with inputs whose rounded value lands just beyond a symmetric bound, and with an input that would clamp before the shift but not after it. It judges the result by whether the bound or the shifted value appears one clock later. Lane independence is a second source of overlap: one cycle drives eight different values, so that some lanes clamp while others pass, and each lane is compared with its own expected value.

// File: rtl/rsat_pkg.sv
package rsat_pkg;

    localparam int SAT_BITS = 3;
    localparam int IDX_BITS = 5;
    localparam int RND_BITS = 2;
    localparam int NUM_BOUND_WORDS = 4;

    typedef enum logic [SAT_BITS-1:0] {
        SAT_NONE    = 3'd0,
        SAT_SYMM    = 3'd1,
        SAT_ASYMM   = 3'd2,
        SAT_REPLACE = 3'd3,
        SAT_SYMM_W  = 3'd4,
        SAT_ASYMM_W = 3'd5
    } sat_mode_e;

    typedef enum logic [RND_BITS-1:0] {
        RND_OFF   = 2'd0,
        RND_NEAR  = 2'd1,
        RND_TRUNC = 2'd2,
        RND_RSVD  = 2'd3
    } rnd_mode_e;

endpackage

// File: rtl/rsat_bound_decode.sv
module rsat_bound_decode
    import rsat_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CMP_W  = 42
) (
    input  logic [SAT_BITS-1:0]               sat_bits,
    input  logic [NUM_BOUND_WORDS*WORD_W-1:0] words,
    input  logic                              is_signed,
    output logic                              sat_en,
    output logic                              repl_en,
    output logic signed [CMP_W-1:0]           lo,
    output logic signed [CMP_W-1:0]           hi,
    output logic signed [CMP_W-1:0]           lo_val,
    output logic signed [CMP_W-1:0]           hi_val
);
    localparam int PAIR_W = 2 * WORD_W;

    logic [WORD_W-1:0] w0, w1, w2, w3;
    assign w0 = words[0*WORD_W +: WORD_W];
    assign w1 = words[1*WORD_W +: WORD_W];
    assign w2 = words[2*WORD_W +: WORD_W];
    assign w3 = words[3*WORD_W +: WORD_W];

    function automatic logic signed [CMP_W-1:0] widen1(input logic [WORD_W-1:0] v, input logic sg);
        return sg ? {{(CMP_W-WORD_W){v[WORD_W-1]}}, v} : {{(CMP_W-WORD_W){1'b0}}, v};
    endfunction

    function automatic logic signed [CMP_W-1:0] widen2(input logic [PAIR_W-1:0] v, input logic sg);
        return sg ? {{(CMP_W-PAIR_W){v[PAIR_W-1]}}, v} : {{(CMP_W-PAIR_W){1'b0}}, v};
    endfunction

    always_comb begin
        sat_en  = 1'b1;
        repl_en = 1'b0;
        lo      = '0;
        hi      = '0;
        lo_val  = '0;
        hi_val  = '0;
        case (sat_mode_e'(sat_bits))
            SAT_SYMM: begin
                hi = widen1(w0, is_signed);
                lo = -hi;
            end
            SAT_ASYMM: begin
                lo = widen1(w0, is_signed);
                hi = widen1(w1, is_signed);
            end
            SAT_REPLACE: begin
                lo      = widen1(w0, is_signed);
                hi      = widen1(w1, is_signed);
                lo_val  = widen1(w2, is_signed);
                hi_val  = widen1(w3, is_signed);
                repl_en = 1'b1;
            end
            SAT_SYMM_W: begin
                hi = widen2({w1, w0}, is_signed);
                lo = -hi;
            end
            SAT_ASYMM_W: begin
                lo = widen2({w1, w0}, is_signed);
                hi = widen2({w3, w2}, is_signed);
            end
            default: sat_en = 1'b0;
        endcase
    end

    // unsigned bounds can never give a negative symmetric limit
    always_comb begin
        if (!is_signed && sat_en && (sat_bits == SAT_SYMM || sat_bits == SAT_SYMM_W)) begin
            assert_unsigned_nonneg_R12: assert (hi >= 0 && lo <= 0)
                else $error("unsigned symmetric bound decoded negative");
        end
    end

endmodule

// File: rtl/rsat_shift.sv
module rsat_shift
    import rsat_pkg::*;
#(
    parameter int LANE_W = 40,
    parameter int SH_W   = 6
) (
    input  logic signed [LANE_W-1:0] x,
    input  logic [RND_BITS-1:0]      rnd_bits,
    input  logic [SH_W-1:0]          sh,
    output logic signed [LANE_W-1:0] y
);
    localparam int EXT_W = LANE_W + (1 << SH_W) + 1;

    logic                    shift_on;
    logic                    add_half;
    logic [SH_W-1:0]         sh_eff;
    logic signed [EXT_W-1:0] ext;
    logic signed [EXT_W-1:0] half;
    logic signed [EXT_W-1:0] sum;
    logic signed [EXT_W-1:0] shifted;
    logic                    unused_ext_hi;

    always_comb begin
        shift_on = (rnd_bits == RND_NEAR) || (rnd_bits == RND_TRUNC);
        add_half = (rnd_bits == RND_NEAR);
        sh_eff   = shift_on ? sh : '0;
        ext      = {{(EXT_W-LANE_W){x[LANE_W-1]}}, x};
        half     = (add_half && sh_eff != '0) ? (EXT_W'(1) << (sh_eff - 1'b1)) : '0;
        sum      = ext + half;
        shifted  = sum >>> sh_eff;
    end

    assign y             = shifted[LANE_W-1:0];
    assign unused_ext_hi = ^shifted[EXT_W-1:LANE_W];

    // truncation result is the floor: y*2^s <= x < (y+1)*2^s
    always_comb begin
        if (shift_on && !add_half && sh_eff < SH_W'(LANE_W)) begin
            assert_trunc_floor_R6: assert (((shifted <<< sh_eff) <= ext) &&
                                           ((ext - (shifted <<< sh_eff)) < $signed(EXT_W'(1) << sh_eff)))
                else $error("truncating shift is not a floor");
        end
    end

endmodule

// File: rtl/rsat_clamp.sv
module rsat_clamp #(
    parameter int LANE_W = 40,
    parameter int CMP_W  = 42
) (
    input  logic signed [LANE_W-1:0] y,
    input  logic                     sat_en,
    input  logic                     repl_en,
    input  logic signed [CMP_W-1:0]  lo,
    input  logic signed [CMP_W-1:0]  hi,
    input  logic signed [CMP_W-1:0]  lo_val,
    input  logic signed [CMP_W-1:0]  hi_val,
    output logic signed [LANE_W-1:0] z
);
    logic signed [CMP_W-1:0] ye;
    logic signed [CMP_W-1:0] r;
    logic                    unused_r_hi;

    always_comb begin
        ye = {{(CMP_W-LANE_W){y[LANE_W-1]}}, y};
        if (!sat_en) begin
            r = ye;
        end else if (ye > hi) begin
            r = repl_en ? hi_val : hi;
        end else if (ye < lo) begin
            r = repl_en ? lo_val : lo;
        end else begin
            r = ye;
        end
    end

    assign z           = r[LANE_W-1:0];
    assign unused_r_hi = ^r[CMP_W-1:LANE_W];

    always_comb begin
        if (sat_en && !repl_en && lo <= hi) begin
            assert_clamp_window_R9: assert (r >= lo && r <= hi)
                else $error("clamped value left its window");
        end
        if (sat_en && ye >= lo && ye <= hi) begin
            assert_inrange_kept_R7: assert (r == ye)
                else $error("in-range value was altered by the clamp");
        end
    end

endmodule

// File: rtl/rsat_store_cond.sv
module rsat_store_cond
    import rsat_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 40,
    parameter int WORD_W = 16,
    parameter int SH_W   = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [LANES*LANE_W-1:0]           lane_in,
    input  logic [SAT_BITS+IDX_BITS+RND_BITS+SH_W-1:0] ctrl_word,
    input  logic [NUM_BOUND_WORDS*WORD_W-1:0] bound_words,
    input  logic                              bound_signed,
    output logic [LANES*LANE_W-1:0]           lane_out
);
    localparam int CTRL_W  = SAT_BITS + IDX_BITS + RND_BITS + SH_W;
    localparam int WIDE_W  = (LANE_W > 2*WORD_W) ? LANE_W : 2*WORD_W;
    localparam int CMP_W   = WIDE_W + 2;
    localparam int RND_LSB = SH_W;
    localparam int IDX_LSB = SH_W + RND_BITS;
    localparam int SAT_LSB = IDX_LSB + IDX_BITS;

    typedef struct packed {
        logic [LANES*LANE_W-1:0] lanes;
    } state_t;

    state_t state_d, state_q;

    logic [SAT_BITS-1:0]     sat_bits;
    logic [IDX_BITS-1:0]     unused_idx;
    logic [RND_BITS-1:0]     rnd_bits;
    logic [SH_W-1:0]         sh;
    logic                    sat_en, repl_en;
    logic signed [CMP_W-1:0] lo, hi, lo_val, hi_val;
    logic [LANES*LANE_W-1:0] lane_res;

    assign sat_bits   = ctrl_word[SAT_LSB +: SAT_BITS];
    assign unused_idx = ctrl_word[IDX_LSB +: IDX_BITS];
    assign rnd_bits   = ctrl_word[RND_LSB +: RND_BITS];
    assign sh         = ctrl_word[0 +: SH_W];

    rsat_bound_decode #(
        .WORD_W (WORD_W),
        .CMP_W  (CMP_W)
    ) u_decode (
        .sat_bits  (sat_bits),
        .words     (bound_words),
        .is_signed (bound_signed),
        .sat_en    (sat_en),
        .repl_en   (repl_en),
        .lo        (lo),
        .hi        (hi),
        .lo_val    (lo_val),
        .hi_val    (hi_val)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [LANE_W-1:0] shifted;

        rsat_shift #(
            .LANE_W (LANE_W),
            .SH_W   (SH_W)
        ) u_shift (
            .x        (lane_in[g*LANE_W +: LANE_W]),
            .rnd_bits (rnd_bits),
            .sh       (sh),
            .y        (shifted)
        );

        rsat_clamp #(
            .LANE_W (LANE_W),
            .CMP_W  (CMP_W)
        ) u_clamp (
            .y       (shifted),
            .sat_en  (sat_en),
            .repl_en (repl_en),
            .lo      (lo),
            .hi      (hi),
            .lo_val  (lo_val),
            .hi_val  (hi_val),
            .z       (lane_res[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.lanes = lane_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lane_out = state_q.lanes;

    // all-zero control: the next output equals the present input
    assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word == CTRL_W'(0)) |=> (lane_out == $past(lane_in)))
        else $error("zero control word did not pass lanes through");

    // equal lane inputs give equal lane outputs one edge later
    assert_lane_match_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_in[0 +: LANE_W] == lane_in[(LANES-1)*LANE_W +: LANE_W])
        |=> (lane_out[0 +: LANE_W] == lane_out[(LANES-1)*LANE_W +: LANE_W]))
        else $error("identical lanes produced different results");

endmodule

// File: tb/sim_rsat_store_cond.sv
`timescale 1ns/1ps
module sim_rsat_store_cond;

    localparam int LANES = 8;
    localparam int LW    = 40;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [LANES*LW-1:0] lane_in = '0;
    logic [15:0]     ctrl_word = '0;
    logic [63:0]     bound_words = '0;
    logic            bound_signed = 1'b1;
    logic [LANES*LW-1:0] lane_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rsat_store_cond u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_in      (lane_in),
        .ctrl_word    (ctrl_word),
        .bound_words  (bound_words),
        .bound_signed (bound_signed),
        .lane_out     (lane_out)
    );

    // layout per R3: [15:13] clamp, [12:8] index, [7:6] shift mode, [5:0] count
    function automatic logic [15:0] mk(input int sat, input int idx, input int rnd, input int sh);
        return {sat[2:0], idx[4:0], rnd[1:0], sh[5:0]};
    endfunction

    typedef struct packed {
        logic [15:0] c;
        logic [63:0] w;
        logic        s;
        logic [39:0] x;
        logic [39:0] e;
        logic [7:0]  r;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        '{mk(0,0,0,0),  64'd0, 1'b1, 40'sd123456789, 40'sd123456789, 8'd4},  // R4
        '{mk(0,0,0,0),  64'd0, 1'b1, -40'sd5, -40'sd5, 8'd4},                // R4
        '{mk(0,0,0,5),  64'd0, 1'b1, 40'sd1000, 40'sd1000, 8'd4},            // R4 off ignores count
        '{mk(0,0,3,4),  64'd0, 1'b1, 40'sd40, 40'sd40, 8'd4},                // R4 mode 3
        '{mk(0,0,1,4),  64'd0, 1'b1, 40'sd40, 40'sd3, 8'd5},                 // R5
        '{mk(0,0,1,4),  64'd0, 1'b1, -40'sd40, -40'sd2, 8'd5},               // R5
        '{mk(0,0,1,4),  64'd0, 1'b1, -40'sd41, -40'sd3, 8'd5},               // R5
        '{mk(0,0,1,0),  64'd0, 1'b1, 40'sd77, 40'sd77, 8'd5},                // R5 count 0
        '{mk(0,0,1,39), 64'd0, 1'b1, 40'sd549755813887, 40'sd1, 8'd5},       // R5 max lane
        '{mk(0,0,1,45), 64'd0, 1'b1, -40'sd1, 40'sd0, 8'd5},                 // R5 huge count
        '{mk(0,0,2,4),  64'd0, 1'b1, -40'sd40, -40'sd3, 8'd6},               // R6
        '{mk(0,0,2,4),  64'd0, 1'b1, 40'sd47, 40'sd2, 8'd6},                 // R6
        '{mk(0,0,2,63), 64'd0, 1'b1, -40'sd5, -40'sd1, 8'd6},                // R6
        '{mk(1,0,0,0),  64'd100, 1'b1, 40'sd500, 40'sd100, 8'd8},            // R8
        '{mk(1,0,0,0),  64'd100, 1'b1, -40'sd500, -40'sd100, 8'd8},          // R8
        '{mk(1,0,0,0),  64'd100, 1'b1, 40'sd50, 40'sd50, 8'd8},              // R8
        '{mk(1,0,1,2),  64'd100, 1'b1, 40'sd300, 40'sd75, 8'd7},             // R7 shift before clamp
        '{mk(6,0,0,0),  64'd100, 1'b1, 40'sd500, 40'sd500, 8'd7},            // R7 mode 6
        '{mk(2,0,0,0),  {32'd0,16'd30,16'hFFEC}, 1'b1, -40'sd100, -40'sd20, 8'd9},  // R9
        '{mk(2,0,0,0),  {32'd0,16'd30,16'hFFEC}, 1'b1, 40'sd100, 40'sd30, 8'd9},    // R9
        '{mk(2,0,0,0),  {32'd0,16'd30,16'hFFEC}, 1'b1, 40'sd0, 40'sd0, 8'd9},       // R9
        '{mk(2,0,0,0),  {32'd0,16'hFFFF,16'hFFEC}, 1'b0, 40'sd0, 40'sd65516, 8'd12},// R12 unsigned
        '{mk(2,0,0,0),  {32'd0,16'hFFFF,16'hFFEC}, 1'b1, 40'sd0, -40'sd1, 8'd12},   // R12 signed
        '{mk(2,0,0,0),  {32'd0,16'd10,16'd50}, 1'b1, 40'sd30, 40'sd10, 8'd9},       // R9 upper first
        '{mk(3,0,0,0),  {16'd999,16'hFC19,16'd10,16'hFFF6}, 1'b1, 40'sd11, 40'sd999, 8'd10},   // R10
        '{mk(3,0,0,0),  {16'd999,16'hFC19,16'd10,16'hFFF6}, 1'b1, -40'sd11, -40'sd999, 8'd10}, // R10
        '{mk(3,0,0,0),  {16'd999,16'hFC19,16'd10,16'hFFF6}, 1'b1, 40'sd10, 40'sd10, 8'd10},    // R10
        '{mk(3,0,0,0),  {16'd999,16'hFC19,16'd10,16'hFFF6}, 1'b1, -40'sd10, -40'sd10, 8'd10},  // R10
        '{mk(4,0,0,0),  {32'd0,16'h0001,16'h0000}, 1'b1, 40'sd1000000, 40'sd65536, 8'd11},     // R11
        '{mk(4,0,0,0),  {32'd0,16'h0001,16'h0000}, 1'b1, -40'sd1000000, -40'sd65536, 8'd11},   // R11
        '{mk(4,0,0,0),  {32'd0,16'hFFFF,16'hFFFF}, 1'b0, 40'sd274877906944, 40'sd4294967295, 8'd12},   // R12
        '{mk(4,0,0,0),  {32'd0,16'hFFFF,16'hFFFF}, 1'b0, -40'sd274877906944, -40'sd4294967295, 8'd11}, // R11
        '{mk(5,0,0,0),  {16'h0002,16'h0000,16'hFFFF,16'h0000}, 1'b1, -40'sd1000000, -40'sd65536, 8'd11}, // R11
        '{mk(5,0,0,0),  {16'h0002,16'h0000,16'hFFFF,16'h0000}, 1'b1, 40'sd1000000, 40'sd131072, 8'd11},  // R11
        '{mk(0,31,0,0), 64'd0, 1'b1, 40'sd424242, 40'sd424242, 8'd3},        // R3 index ignored
        '{mk(1,7,0,0),  64'd100, 1'b1, 40'sd500, 40'sd100, 8'd3},            // R3 index ignored
        '{mk(7,0,0,0),  64'd100, 1'b1, -40'sd500, -40'sd500, 8'd7},          // R7 mode 7
        '{mk(1,0,1,2),  64'd100, 1'b1, 40'sd402, 40'sd100, 8'd7},            // R7 round then clamp
        '{mk(1,0,1,2),  64'd100, 1'b1, -40'sd403, -40'sd100, 8'd7}           // R7 round then clamp
    };

    task automatic check(input bit ok, input string req, input logic [LANES*LW-1:0] act,
                         input logic [LANES*LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [LANES*LW-1:0] exp;

        // R1: reset holds zero even with live inputs
        lane_in   = {LANES{40'sd5}};
        ctrl_word = 16'd0;
        repeat (3) @(negedge clk);
        check(lane_out == '0, "R1", lane_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(lane_out == {LANES{40'sd5}}, "R4", lane_out, {LANES{40'sd5}});

        // R2: one-edge latency, output holds between edges
        lane_in = {LANES{40'sd111}};
        @(negedge clk);
        lane_in = {LANES{40'sd222}};
        #1;
        check(lane_out == {LANES{40'sd111}}, "R2 hold", lane_out, {LANES{40'sd111}});
        @(negedge clk);
        check(lane_out == {LANES{40'sd222}}, "R2 update", lane_out, {LANES{40'sd222}});

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ctrl_word    = VECS[i].c;
            bound_words  = VECS[i].w;
            bound_signed = VECS[i].s;
            lane_in      = {LANES{VECS[i].x}};
            @(negedge clk);
            exp = {LANES{VECS[i].e}};
            if (lane_out != exp) begin
                checks++;
                errors++;
                $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[i].r, i, lane_out, exp);
            end else begin
                checks++;
            end
        end

        // R13: distinct values per lane, symmetric clamp at 100
        @(negedge clk);
        ctrl_word    = mk(1, 0, 0, 0);
        bound_words  = 64'd100;
        bound_signed = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            lane_in[k*LW +: LW] = 40'((k - 4) * 60);
        end
        for (int k = 0; k < LANES; k++) begin
            int v;
            v = (k - 4) * 60;
            exp[k*LW +: LW] = 40'((v > 100) ? 100 : ((v < -100) ? -100 : v));
        end
        @(negedge clk);
        check(lane_out == exp, "R13", lane_out, exp);

        // R1: asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        check(lane_out == '0, "R1 async", lane_out, '0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule